// File: doc/BRIEF.md
# Centre-Aligned PWM Gray-Shade Generator

This block converts a bank of latched gray values into pulse-width-modulated outputs, one per channel. Every channel shares a single master counter. A load strobe starts a frame. The counter then walks down from its maximum to 1, pauses for one step, and walks back up to its maximum. A channel turns on when the falling count equals its value and turns off when the rising count equals it again. Each pulse is therefore centred on the turning point of the ramp, and its width grows with the gray value.

The count clock is an asynchronous input. It is synchronised into the system clock domain, and both its rising and its falling transitions advance the counter. A blank input aborts the frame and forces every output to the inactive level. A polarity input inverts all outputs, including the level that blank forces. The block is meant to sit between a data latch stage and the output drivers of a display column driver.

Top module: `pwm_gs_gen`

## Requirements
- R1: After reset, with polarity high and blank low, every output is low and the rise flag is low.
- R2: A load strobe puts the counter at its maximum (255 for 8-bit values) in the falling phase. A channel holding 255 goes high immediately, before any count edge.
- R3: A channel with a nonzero value v goes high after 255−v count edges following the load, that is, when the falling count reaches v.
- R4: A channel that is high goes low when the rising count reaches its value again. This happens after 254+v count edges, so the pulse lasts 2v−1 count edges. A value of 1 is high for exactly one edge.
- R5: A channel holding 0 never goes high during a frame.
- R6: The rise flag is low during the falling phase. It goes high on the 255th count edge, when the counter holds at 1 for one extra edge. It stays high up to and including edge 509, while the counter holds at 255 for one extra edge.
- R7: The frame ends on the 510th count edge. Later count edges change no output until the next load strobe.
- R8: While blank is high and polarity is high, every output is low. Blank also returns the counter to its maximum and abandons the frame, so later count edges produce no pulse.
- R9: While blank is high and polarity is low, every output is high.
- R10: With polarity low, each output is the exact inverse of the value it has with polarity high, at every point of the frame.
- R11: Both the rising and the falling transitions of the count clock advance the counter by one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_clk | input | 1 | Asynchronous count clock; each transition is one step |
| load_cnt | input | 1 | One-cycle strobe that starts a frame |
| blank | input | 1 | Abort the frame and force the outputs to the inactive level |
| pol | input | 1 | Output polarity; 1 = active high |
| gray_in | input | NCH*VW (256) | Channel values; channel i occupies bits [i*VW +: VW] |
| drv_out | output | NCH (32) | Per-channel PWM outputs |
| ramp_up | output | 1 | High while the counter is in the rising phase |

## Verification
The main sweep loads a mix of values: the extremes 255 and 1, the null value 0, the midpoint 128, the near-maximum 254, and a scattered spread. It compares every output after every count edge against a closed-form window model. This separates the turn-on edge from the turn-off edge, catches off-by-one errors at both turning points, and shows whether the null value stays silent. The same sweep is repeated with polarity low to confirm exact inversion. Blank is asserted in the middle of a frame under both polarities to confirm the forced level and that the frame is dropped. Edges counted after the frame ends show that the block stays idle until the next load.

// File: rtl/pwm_gs_pkg.sv
package pwm_gs_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_FALL = 2'd1,
      PH_RISE = 2'd2
   } ramp_phase_t;
endpackage

// File: rtl/pwm_gs_edge_det.sv
module pwm_gs_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic any_edge
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("pwm_gs_edge_det: SYNC_STAGES must be at least 2");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   assign any_edge = sync_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/pwm_gs_ramp.sv
module pwm_gs_ramp
   import pwm_gs_pkg::*;
#(
   parameter int VW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          blank,
   input  logic          load,
   input  logic          step,
   output logic [VW-1:0] cnt,
   output ramp_phase_t   phase,
   output logic          fresh
);
   localparam logic [VW-1:0] TOP = {VW{1'b1}};
   localparam logic [VW-1:0] ONE = VW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= TOP;
         phase <= PH_IDLE;
         fresh <= 1'b0;
      end else begin
         fresh <= 1'b0;
         if (blank) begin
            cnt   <= TOP;
            phase <= PH_IDLE;
         end else if (load) begin
            cnt   <= TOP;
            phase <= PH_FALL;
            fresh <= 1'b1;
         end else if (step) begin
            case (phase)
               PH_FALL: begin
                  if (cnt > ONE) cnt   <= cnt - ONE;
                  else           phase <= PH_RISE;
                  fresh <= 1'b1;
               end
               PH_RISE: begin
                  if (cnt < TOP) begin
                     cnt   <= cnt + ONE;
                     fresh <= 1'b1;
                  end else begin
                     phase <= PH_IDLE;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/pwm_gs_chan.sv
module pwm_gs_chan
   import pwm_gs_pkg::*;
#(
   parameter int VW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          blank,
   input  logic          fresh,
   input  logic [VW-1:0] cnt,
   input  ramp_phase_t   phase,
   input  logic [VW-1:0] level,
   output logic          pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n || blank) begin
         pulse <= 1'b0;
      end else if (fresh && (level != '0) && (level == cnt)) begin
         pulse <= (phase == PH_FALL);
      end
   end
endmodule

// File: rtl/pwm_gs_gen.sv
module pwm_gs_gen
   import pwm_gs_pkg::*;
#(
   parameter int NCH         = 32,
   parameter int VW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_clk,
   input  logic              load_cnt,
   input  logic              blank,
   input  logic              pol,
   input  logic [NCH*VW-1:0] gray_in,
   output logic [NCH-1:0]    drv_out,
   output logic              ramp_up
);
   localparam int GW = NCH * VW;

   logic              step;
   logic [VW-1:0]     cnt_q;
   ramp_phase_t       phase_q;
   logic              fresh_q;
   logic [NCH-1:0]    raw_q;

   generate
      if (NCH < 1)  begin : g_bad_nch $error("pwm_gs_gen: NCH must be positive"); end
      if (VW < 2)   begin : g_bad_vw  $error("pwm_gs_gen: VW must be at least 2"); end
      if (GW > 4096) begin : g_bad_gw $error("pwm_gs_gen: gray bus too wide"); end
   endgenerate

   pwm_gs_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (cnt_clk),
      .any_edge (step)
   );

   pwm_gs_ramp #(.VW(VW)) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .blank (blank),
      .load  (load_cnt),
      .step  (step),
      .cnt   (cnt_q),
      .phase (phase_q),
      .fresh (fresh_q)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_chan
         pwm_gs_chan #(.VW(VW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .blank (blank),
            .fresh (fresh_q),
            .cnt   (cnt_q),
            .phase (phase_q),
            .level (gray_in[c*VW +: VW]),
            .pulse (raw_q[c])
         );
      end
   endgenerate

   assign drv_out = blank ? {NCH{~pol}} : (raw_q ^ {NCH{~pol}});
   assign ramp_up = (phase_q == PH_RISE);
endmodule

// File: rtl/pwm_gs_chk.sv
module pwm_gs_chk
   import pwm_gs_pkg::*;
#(
   parameter int NCH = 32,
   parameter int VW  = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           blank,
   input logic           pol,
   input logic           load_cnt,
   input logic           step,
   input logic [VW-1:0]  cnt,
   input ramp_phase_t    phase,
   input logic [NCH-1:0] drv_out
);
   localparam logic [VW-1:0] TOP = {VW{1'b1}};

   // R8
   blank_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blank |=> (cnt == TOP && phase == PH_IDLE));

   // R9
   blank_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> (drv_out == {NCH{~pol}}));

   // R2
   load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_cnt && !blank) |=> (cnt == TOP && phase == PH_FALL));

   // R3
   fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load_cnt && !blank && phase == PH_FALL && cnt > VW'(1))
      |=> (cnt == $past(cnt) - 1'b1 && phase == PH_FALL));

   // R4
   rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load_cnt && !blank && phase == PH_RISE && cnt < TOP)
      |=> (cnt == $past(cnt) + 1'b1 && phase == PH_RISE));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && !load_cnt) |=> (phase == PH_IDLE && cnt == TOP));

   // R5
   cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt != '0);
endmodule

bind pwm_gs_gen pwm_gs_chk #(.NCH(NCH), .VW(VW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .blank    (blank),
   .pol      (pol),
   .load_cnt (load_cnt),
   .step     (step),
   .cnt      (cnt_q),
   .phase    (phase_q),
   .drv_out  (drv_out)
);

// File: tb/pwm_gs_gen_test.sv
`timescale 1ns/1ps
module pwm_gs_gen_test;
   localparam int NCH = 32;
   localparam int VW  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cnt_clk = 1'b0;
   logic              load_cnt = 1'b0;
   logic              blank = 1'b0;
   logic              pol = 1'b1;
   logic [NCH*VW-1:0] gray_in = '0;
   logic [NCH-1:0]    drv_out;
   logic              ramp_up;

   int checks = 0;
   int fails  = 0;

   pwm_gs_gen #(.NCH(NCH), .VW(VW)) uut (
      .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .load_cnt(load_cnt),
      .blank(blank), .pol(pol), .gray_in(gray_in), .drv_out(drv_out),
      .ramp_up(ramp_up)
   );

   always #5 clk = ~clk;

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int val_of(input int c);
      return int'(gray_in[c*VW +: VW]);
   endfunction

   function automatic logic [NCH-1:0] model(input int e, input logic p);
      logic [NCH-1:0] m;
      for (int c = 0; c < NCH; c++) begin
         int v = val_of(c);
         logic h = (v != 0) && (e >= 255 - v) && (e < 254 + v) && (e < 510);
         m[c] = h ^ ~p;
      end
      return m;
   endfunction

   task automatic toggle_edge();
      cnt_clk = ~cnt_clk;
      settle(6);
   endtask

   task automatic pulse_load();
      load_cnt = 1'b1;
      settle(1);
      load_cnt = 1'b0;
      settle(3);
   endtask

   task automatic test_reset();
      check("R1 outputs", 64'(drv_out), 64'(0));
      check("R1 ramp_up", 64'(ramp_up), 64'(0));
   endtask

   // R2 R3 R4 R5 R6 R7 R10 R11: full frame compared edge by edge
   task automatic test_frame(input logic p);
      pol = p;
      settle(1);
      check("R7 idle before load", 64'(drv_out), 64'(model(600, p)));
      pulse_load();
      check("R2 after load", 64'(drv_out), 64'(model(0, p)));
      for (int e = 1; e <= 515; e++) begin
         toggle_edge();
         check(p ? "R3,R4,R5,R11 frame" : "R10 inverted frame",
               64'(drv_out), 64'(model(e, p)));
         check("R6 ramp_up", 64'(ramp_up), 64'((e >= 255) && (e <= 509)));
      end
   endtask

   task automatic test_blank(input logic p);
      pol = p;
      pulse_load();
      for (int e = 0; e < 100; e++) toggle_edge();
      blank = 1'b1;
      settle(1);
      check(p ? "R8 blank forces low" : "R9 blank forces high",
            64'(drv_out), 64'({NCH{~p}}));
      settle(3);
      check(p ? "R8 blank held" : "R9 blank held", 64'(drv_out), 64'({NCH{~p}}));
      blank = 1'b0;
      settle(2);
      for (int e = 0; e < 300; e++) toggle_edge();
      check("R8 frame abandoned", 64'(drv_out), 64'({NCH{~p}}));
      check("R8 no rise after blank", 64'(ramp_up), 64'(0));
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) gray_in[c*VW +: VW] = VW'((c * 37 + 11) % 256);
      gray_in[0*VW +: VW] = 8'd255;
      gray_in[1*VW +: VW] = 8'd1;
      gray_in[2*VW +: VW] = 8'd0;
      gray_in[3*VW +: VW] = 8'd128;
      gray_in[4*VW +: VW] = 8'd254;
      gray_in[5*VW +: VW] = 8'd2;
      settle(4);
      rst_n = 1'b1;
      settle(4);
      test_reset();
      test_frame(1'b1);
      test_frame(1'b0);
      test_blank(1'b1);
      test_blank(1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule